// File: doc/BRIEF.md
# Mixed-Width Dual-Clock FIFO

This block is a first-in first-out queue whose producer and consumer run on unrelated clocks and use different word widths. One side is wider than the other by a power-of-two factor, and either side may be the wide one. A wide word travelling to a narrow port is cut into narrow slices, least-significant slice first. Narrow words travelling to a wide port are packed so that the earliest one lands in the least-significant slice.

Both sides keep their position in units of the narrow word. Each side passes its position to the other clock domain as a Gray-coded count in its own word unit, through a two-flop synchronizer. Each side reports its fill level in its own word size, and the full and empty flags are conservative. A single asynchronous clear input is resynchronized separately into each clock domain. Storage is split into one bank per narrow slice, so each bank can map onto a block RAM.

Top module: `mwf_fifo`

## Requirements
- R1: After clear, the read side reports empty with a used count of 0 and read data of all zeros. The write side reports not full with a used count of 0.
- R2: The write-side used count is the number of stored narrow slots divided by the write-to-narrow width ratio, rounded down. An accepted write raises it by one on the next write-clock edge, and reads lower it once they have crossed into the write domain.
- R3: The read-side used count is the number of stored narrow slots divided by the read-to-narrow width ratio, rounded down. After two 16-bit writes into an 8-bit read port, it reads 4 once the write position has crossed.
- R4: With a wide write port and a narrow read port, each wide word comes out with bits [NW-1:0] first and the highest slice last.
- R5: With a narrow write port and a wide read port, the first narrow word written appears in bits [NW-1:0] of the wide read word, and later words fill higher slices.
- R6: Read-side empty is asserted while fewer narrow slots are stored than one read word needs. For example, three bytes give empty on a 32-bit read port.
- R7: Write-side full is asserted when fewer free narrow slots remain than one write word needs. A write request while full stores nothing and leaves the write position unchanged.
- R8: A read request while empty leaves the read data and the read position unchanged.
- R9: Read data is registered. It changes only on the read-clock edge that accepts a read, and holds its value otherwise.
- R10: Asserting the asynchronous clear empties the queue in both clock domains, each through its own reset synchronizer. After the clear is released the queue works normally.
- R11: The order of the data is preserved when writes and reads overlap and the read clock runs at a different rate from the write clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_req | input | 1 | Write request; accepted when not full |
| wr_data | input | WR_W | Data word to store |
| wr_full | output | 1 | No room for one more write word |
| wr_used | output | ADDR_W+1-log2(WR_W/min(WR_W,RD_W)) | Stored data counted in write words |
| rd_clk | input | 1 | Read-domain clock |
| rd_req | input | 1 | Read request; accepted when not empty |
| rd_data | output | RD_W | Registered read word |
| rd_empty | output | 1 | Less than one read word stored |
| rd_used | output | ADDR_W+1-log2(RD_W/min(WR_W,RD_W)) | Stored data counted in read words |
| aclr | input | 1 | Asynchronous clear for both domains |

## Verification
The bench builds two copies of the block, both with 32 narrow slots (ADDR_W=5), and runs the read clock at twice the write frequency. The first copy writes 16 bits and reads 8 bits (ratio 2). It exercises slice order on the narrow read side, the 2/4 used-count pair, filling to full after sixteen words and a write that is dropped while full. The second copy writes 8 bits and reads 32 bits (ratio 4). It exercises packing order on the wide read side, and shows that a partial wide word of three bytes still reads as empty.

// File: rtl/mwf_pkg.sv
package mwf_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/mwf_rst_sync.sv
module mwf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_in,
  output logic rst_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) sh <= {sh[STAGES-2:0], clr_in};

  assign rst_out = sh[STAGES-1];
endmodule

// File: rtl/mwf_gray_sync.sv
module mwf_gray_sync #(
  parameter int GW = 6,
  parameter int PW = 6,
  localparam int LSH = PW - GW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  import mwf_pkg::*;

  logic [GW-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  // the low LSH bits of the peer position are always zero
  assign bin_out = PW'(from_gray(32'(s2))) << LSH;
endmodule

// File: rtl/mwf_ptr_ctl.sv
module mwf_ptr_ctl #(
  parameter int PW    = 6,
  parameter int LINC  = 0,
  parameter bit IS_WR = 1'b1,
  localparam int GW = PW - LINC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [PW-1:0] peer,
  output logic [PW-2:0] addr,
  output logic [GW-1:0] gray,
  output logic          flag,
  output logic [GW-1:0] used,
  output logic          accept
);
  import mwf_pkg::*;

  localparam logic [PW-1:0] INC = PW'(1) << LINC;
  localparam logic [PW-1:0] CAP = PW'(1) << (PW - 1);

  logic [PW-1:0] ptr, nxt, fill;
  logic          flag_n;

  assign accept = req & ~flag;
  assign nxt    = accept ? ptr + INC : ptr;
  assign addr   = ptr[PW-2:0];

  generate
    if (IS_WR) begin : g_wr
      assign fill   = nxt - peer;
      assign flag_n = fill > (CAP - INC);
    end else begin : g_rd
      assign fill   = peer - nxt;
      assign flag_n = fill < INC;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      gray <= '0;
      flag <= ~IS_WR;
      used <= '0;
    end else begin
      ptr  <= nxt;
      gray <= GW'(to_gray(32'(nxt >> LINC)));
      flag <= flag_n;
      used <= GW'(fill >> LINC);
    end
  end
endmodule

// File: rtl/mwf_store.sv
module mwf_store #(
  parameter int NW      = 8,
  parameter int RATIO   = 2,
  parameter int AW      = 5,
  parameter bit WR_WIDE = 1'b1,
  parameter bit RD_WIDE = 1'b0,
  localparam int LR   = $clog2(RATIO),
  localparam int LRS  = (LR > 0) ? LR : 1,
  localparam int ROWS = (1 << AW) / RATIO,
  localparam int RAW  = AW - LR,
  localparam int WW   = WR_WIDE ? NW * RATIO : NW,
  localparam int RW   = RD_WIDE ? NW * RATIO : NW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [RW-1:0] rdata
);
  logic [RAW-1:0]        wrow, rrow;
  logic [LRS-1:0]        wsel, rsel, sel_q;
  logic [NW*RATIO-1:0]   q_all;

  assign wrow = waddr[AW-1:LR];
  assign rrow = raddr[AW-1:LR];

  generate
    if (LR > 0) begin : g_sel
      assign wsel = waddr[LR-1:0];
      assign rsel = raddr[LR-1:0];
    end else begin : g_nosel
      assign wsel = '0;
      assign rsel = '0;
    end

    for (genvar k = 0; k < RATIO; k++) begin : g_bank
      logic [NW-1:0] mem [ROWS];
      logic [NW-1:0] din;
      logic [NW-1:0] q;
      logic          hit;

      if (WR_WIDE) begin : g_wd
        assign din = wdata[k*NW +: NW];
      end else begin : g_wn
        assign din = wdata[NW-1:0];
      end
      assign hit = we && (WR_WIDE || (wsel == LRS'(k)));

      always_ff @(posedge wclk) begin
        if (hit) mem[wrow] <= din;
      end

      always_ff @(posedge rclk) begin
        if (rrst)    q <= '0;
        else if (re) q <= mem[rrow];
      end

      assign q_all[k*NW +: NW] = q;
    end

    if (RD_WIDE) begin : g_rwide
      assign rdata = q_all;
    end else begin : g_rnarrow
      assign rdata = q_all[int'(sel_q)*NW +: NW];
    end
  endgenerate

  always_ff @(posedge rclk) begin
    if (rrst)    sel_q <= '0;
    else if (re) sel_q <= rsel;
  end
endmodule

// File: rtl/mwf_fifo.sv
module mwf_fifo #(
  parameter int WR_W   = 16,
  parameter int RD_W   = 8,
  parameter int ADDR_W = 5,
  localparam int NW    = (WR_W < RD_W) ? WR_W : RD_W,
  localparam int XW    = (WR_W < RD_W) ? RD_W : WR_W,
  localparam int RATIO = XW / NW,
  localparam int LR    = $clog2(RATIO),
  localparam int PW    = ADDR_W + 1,
  localparam int LWI   = (WR_W > RD_W) ? LR : 0,
  localparam int LRI   = (RD_W > WR_W) ? LR : 0,
  localparam int WUW   = PW - LWI,
  localparam int RUW   = PW - LRI
) (
  input  logic            wr_clk,
  input  logic            wr_req,
  input  logic [WR_W-1:0] wr_data,
  output logic            wr_full,
  output logic [WUW-1:0]  wr_used,
  input  logic            rd_clk,
  input  logic            rd_req,
  output logic [RD_W-1:0] rd_data,
  output logic            rd_empty,
  output logic [RUW-1:0]  rd_used,
  input  logic            aclr
);
  logic              w_rst, r_rst;
  logic              w_acc, r_acc;
  logic [ADDR_W-1:0] w_addr, r_addr;
  logic [WUW-1:0]    w_gray;
  logic [RUW-1:0]    r_gray;
  logic [PW-1:0]     r_ptr_w, w_ptr_r;

  mwf_rst_sync #(.STAGES(2)) u_wrst (.clk(wr_clk), .clr_in(aclr), .rst_out(w_rst));
  mwf_rst_sync #(.STAGES(2)) u_rrst (.clk(rd_clk), .clr_in(aclr), .rst_out(r_rst));

  mwf_ptr_ctl #(.PW(PW), .LINC(LWI), .IS_WR(1'b1)) u_wctl (
    .clk(wr_clk), .rst(w_rst), .req(wr_req), .peer(r_ptr_w),
    .addr(w_addr), .gray(w_gray), .flag(wr_full), .used(wr_used), .accept(w_acc)
  );

  mwf_ptr_ctl #(.PW(PW), .LINC(LRI), .IS_WR(1'b0)) u_rctl (
    .clk(rd_clk), .rst(r_rst), .req(rd_req), .peer(w_ptr_r),
    .addr(r_addr), .gray(r_gray), .flag(rd_empty), .used(rd_used), .accept(r_acc)
  );

  mwf_gray_sync #(.GW(WUW), .PW(PW)) u_w2r (
    .clk(rd_clk), .rst(r_rst), .gray_in(w_gray), .bin_out(w_ptr_r)
  );

  mwf_gray_sync #(.GW(RUW), .PW(PW)) u_r2w (
    .clk(wr_clk), .rst(w_rst), .gray_in(r_gray), .bin_out(r_ptr_w)
  );

  mwf_store #(
    .NW(NW), .RATIO(RATIO), .AW(ADDR_W),
    .WR_WIDE(WR_W > RD_W), .RD_WIDE(RD_W > WR_W)
  ) u_store (
    .wclk(wr_clk), .we(w_acc), .waddr(w_addr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(r_rst), .re(r_acc), .raddr(r_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/mwf_chk.sv
module mwf_chk #(
  parameter int WUW = 5,
  parameter int RUW = 6,
  parameter int RW  = 8,
  localparam logic [WUW-1:0] WCAP = WUW'(1) << (WUW - 1),
  localparam logic [RUW-1:0] RCAP = RUW'(1) << (RUW - 1)
) (
  input logic           wr_clk,
  input logic           w_rst,
  input logic           wr_req,
  input logic           wr_full,
  input logic [WUW-1:0] wr_used,
  input logic           rd_clk,
  input logic           r_rst,
  input logic           rd_req,
  input logic           rd_empty,
  input logic [RW-1:0]  rd_data,
  input logic [RUW-1:0] rd_used
);
  // R2: the write-side count never exceeds the capacity in write words
  p_wcap_r2: assert property (@(posedge wr_clk) disable iff (w_rst)
    wr_used <= WCAP);

  // R3: the read-side count never exceeds the capacity in read words
  p_rcap_r3: assert property (@(posedge rd_clk) disable iff (r_rst)
    rd_used <= RCAP);

  // R7: a request while full never raises the count
  p_no_overflow_r7: assert property (@(posedge wr_clk) disable iff (w_rst)
    (wr_full && wr_req) |=> (wr_used <= $past(wr_used)));

  // R7: full only when at most one write word of room is missing
  p_full_level_r7: assert property (@(posedge wr_clk) disable iff (w_rst)
    wr_full |-> (wr_used >= WCAP - 1'b1));

  // R8: a request while empty leaves the read data alone
  p_no_underflow_r8: assert property (@(posedge rd_clk) disable iff (r_rst)
    (rd_empty && rd_req) |=> $stable(rd_data));

  // R9: read data holds when no read is requested
  p_rdata_hold_r9: assert property (@(posedge rd_clk) disable iff (r_rst)
    !rd_req |=> $stable(rd_data));
endmodule

bind mwf_fifo mwf_chk #(.WUW(WUW), .RUW(RUW), .RW(RD_W)) u_chk (
  .wr_clk(wr_clk), .w_rst(w_rst), .wr_req(wr_req), .wr_full(wr_full),
  .wr_used(wr_used), .rd_clk(rd_clk), .r_rst(r_rst), .rd_req(rd_req),
  .rd_empty(rd_empty), .rd_data(rd_data), .rd_used(rd_used)
);

// File: tb/test_mwf_fifo.sv
module test_mwf_fifo;
  // write clock: 10 units (100 MHz); read clock twice as fast
  logic wclk = 1'b0, rclk = 1'b0, aclr = 1'b1;
  always #5   wclk = ~wclk;
  always #2.5 rclk = ~rclk;

  // copy A: 16-bit write, 8-bit read
  logic        a_wreq = 1'b0, a_rreq = 1'b0, a_full, a_empty;
  logic [15:0] a_wdata = '0;
  logic [4:0]  a_wused;
  logic [7:0]  a_rdata;
  logic [5:0]  a_rused;
  // copy B: 8-bit write, 32-bit read
  logic        b_wreq = 1'b0, b_rreq = 1'b0, b_full, b_empty;
  logic [7:0]  b_wdata = '0;
  logic [5:0]  b_wused;
  logic [31:0] b_rdata;
  logic [3:0]  b_rused;

  mwf_fifo #(.WR_W(16), .RD_W(8), .ADDR_W(5)) i_mwf_fifo (
    .wr_clk(wclk), .wr_req(a_wreq), .wr_data(a_wdata), .wr_full(a_full), .wr_used(a_wused),
    .rd_clk(rclk), .rd_req(a_rreq), .rd_data(a_rdata), .rd_empty(a_empty), .rd_used(a_rused),
    .aclr(aclr)
  );

  mwf_fifo #(.WR_W(8), .RD_W(32), .ADDR_W(5)) i_mwf_fifo_rev (
    .wr_clk(wclk), .wr_req(b_wreq), .wr_data(b_wdata), .wr_full(b_full), .wr_used(b_wused),
    .rd_clk(rclk), .rd_req(b_rreq), .rd_data(b_rdata), .rd_empty(b_empty), .rd_used(b_rused),
    .aclr(aclr)
  );

  // {written word, expected first byte, expected second byte}
  localparam logic [31:0] VEC [6] = '{
    32'hA53C3CA5, 32'h0F1E1E0F, 32'hFF0000FF,
    32'h80010180, 32'h6B7C7C6B, 32'h55AAAA55
  };

  int checks = 0, errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic a_write(input logic [15:0] d);
    @(negedge wclk); a_wreq = 1'b1; a_wdata = d;
    @(negedge wclk); a_wreq = 1'b0;
  endtask

  task automatic b_write(input logic [7:0] d);
    @(negedge wclk); b_wreq = 1'b1; b_wdata = d;
    @(negedge wclk); b_wreq = 1'b0;
  endtask

  task automatic a_read(output logic [7:0] d);
    @(negedge rclk); a_rreq = 1'b1;
    @(negedge rclk); a_rreq = 1'b0; d = a_rdata;
  endtask

  task automatic b_read(output logic [31:0] d);
    @(negedge rclk); b_rreq = 1'b1;
    @(negedge rclk); b_rreq = 1'b0; d = b_rdata;
  endtask

  task automatic a_read_ready(output logic [7:0] d);
    @(negedge rclk);
    while (a_empty) @(negedge rclk);
    a_read(d);
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(negedge wclk);
  endtask

  initial begin
    logic [7:0]  d8;
    logic [31:0] d32;
    wait_w(6);
    aclr = 1'b0;
    wait_w(6);

    // R1: state after clear
    check("R1 a empty", a_empty, 1);
    check("R1 a full", a_full, 0);
    check("R1 a wused", a_wused, 0);
    check("R1 a rused", a_rused, 0);
    check("R1 a rdata", a_rdata, 0);
    check("R1 b empty", b_empty, 1);
    check("R1 b full", b_full, 0);
    check("R1 b wused", b_wused, 0);

    // R2 R3 R4 R9: two wide words through the narrow read port
    a_write(16'hBEEF);
    check("R2 wused after one", a_wused, 1);
    a_write(16'h1234);
    check("R2 wused after two", a_wused, 2);
    wait_r(12);
    check("R3 rused two words", a_rused, 4);
    check("R6 not empty", a_empty, 0);
    a_read(d8); check("R4 R9 slice0 word0", d8, 8'hEF);
    a_read(d8); check("R4 slice1 word0", d8, 8'hBE);
    a_read(d8); check("R4 slice0 word1", d8, 8'h34);
    a_read(d8); check("R4 slice1 word1", d8, 8'h12);
    check("R6 empty after drain", a_empty, 1);
    check("R3 rused drained", a_rused, 0);
    wait_r(3);
    check("R9 data held while idle", a_rdata, 8'h12);
    wait_w(8);
    check("R2 wused after reads cross", a_wused, 0);

    // R8: read while empty is ignored
    a_read(d8);
    check("R8 data unchanged", d8, 8'h12);
    a_write(16'h00C3);
    wait_r(12);
    a_read(d8); check("R8 position unchanged lo", d8, 8'hC3);
    a_read(d8); check("R8 position unchanged hi", d8, 8'h00);

    // R4 R11: table walked with writer and reader running together
    fork
      begin
        for (int i = 0; i < 6; i++) a_write(VEC[i][31:16]);
      end
      begin
        for (int i = 0; i < 6; i++) begin
          automatic logic [7:0] r;
          a_read_ready(r); check("R4 R11 table first byte", r, VEC[i][15:8]);
          a_read_ready(r); check("R4 R11 table second byte", r, VEC[i][7:0]);
        end
      end
    join
    wait_w(10);

    // R7: fill, overflow attempt, drain
    for (int i = 0; i < 16; i++) begin
      a_write({8'(2*i+1), 8'(2*i)});
      if (i == 14) check("R7 not full at 15", a_full, 0);
    end
    check("R7 full at 16", a_full, 1);
    check("R7 wused at full", a_wused, 16);
    a_write(16'hDEAD);
    check("R7 wused after dropped write", a_wused, 16);
    wait_r(12);
    check("R3 rused full", a_rused, 32);
    for (int k = 0; k < 32; k++) begin
      a_read(d8);
      check("R7 R4 drain order", d8, 8'(k));
    end
    check("R7 nothing extra stored", a_empty, 1);

    // R5 R6: narrow write into wide read
    b_write(8'h11); b_write(8'h22); b_write(8'h33);
    check("R2 b wused three", b_wused, 3);
    wait_r(12);
    check("R6 partial word empty", b_empty, 1);
    check("R6 partial word rused", b_rused, 0);
    b_write(8'h44);
    wait_r(12);
    check("R6 full word not empty", b_empty, 0);
    check("R3 b rused one", b_rused, 1);
    b_read(d32);
    check("R5 packing order", d32, 32'h44332211);
    check("R6 b empty after read", b_empty, 1);

    // R10: clear with data inside
    a_write(16'h5566); a_write(16'h7788);
    wait_r(12);
    check("R10 before clear", a_rused, 4);
    @(negedge wclk); aclr = 1'b1;
    wait_w(5);
    aclr = 1'b0;
    wait_w(6);
    check("R10 empty", a_empty, 1);
    check("R10 rused", a_rused, 0);
    check("R10 wused", a_wused, 0);
    check("R10 full", a_full, 0);
    check("R10 rdata", a_rdata, 0);
    a_write(16'h99AB);
    wait_r(12);
    a_read(d8);
    check("R10 works after clear", d8, 8'hAB);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wclk);
    checks++;
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule